// File: doc/BRIEF.md
# Carry-Save Partial Result Combiner

This block sits at the output of a 16-tap distributed-arithmetic filter that is built from four 4-tap inner-product units. Each unit finishes its bit-serial accumulation with a redundant pair: a sum word and a carry word. Each word is two bits wider than the filter weights. The combiner turns the four pairs into one two's-complement filter output at full precision. It registers that output once per sample.

The sum words go through one binary adder tree and the carry words go through a second, independent tree. The carry total counts at twice the weight of the sum total, so it is shifted left by one bit before the two totals are added. Each unit also needs a +1 to complete the negation of its most significant weight slice. All of these corrections enter as carry-in bits on the first-level adders of the carry tree. There are half as many such bits as units, and the doubled weight of the carry tree supplies the rest. A parameter can place an optional register between the trees and the final adder. This trades one cycle of latency for a shorter path.

Top module: `dacomb_top`

## Requirements
- R1: The registered output equals the sum of all sum words, plus twice the sum of all carry words, plus the number of units (4 by default), as a signed value of OUT_W bits.
- R2: Sum and carry words are read as signed two's-complement words of WORD_W bits. OUT_W is WORD_W + log2(UNITS) + 2. All four pairs at their most positive values, or all four at their most negative, produce the exact result with no wraparound.
- R3: When every sum word and every carry word is zero, the output equals the number of units. This value comes only from the per-unit +1 corrections.
- R4: With TREE_REG = 0, the output loads at the clock edge where all unit done bits are high, and out_valid is high in the cycle after that edge. TREE_REG = 1 adds exactly one cycle to both.
- R5: While any unit done bit is low, the output keeps its previous value and out_valid is low.
- R6: While rst_n is low, filt_out is zero and out_valid is low.
- R7: When all done bits stay high on consecutive edges, each cycle's input set produces its own result and out_valid stays high in every one of those cycles.
- R8: A carry word contributes twice its value. A single carry word of 1, with all other words zero, gives an output of 2 + UNITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sum_words | input | UNITS*WORD_W | Sum words, unit i in bits [i*WORD_W +: WORD_W] |
| carry_words | input | UNITS*WORD_W | Carry words, unit i in bits [i*WORD_W +: WORD_W] |
| unit_done | input | UNITS | Per-unit flag: this sample's pair is final |
| filt_out | output | OUT_W | Signed filter output |
| out_valid | output | 1 | filt_out was updated at the last load edge |

## Verification
Two things fall in the same cycle. The first is the correction injected at the carry tree. The second is the doubled weight applied to the whole carry total. Both change the result at once, so an error in one can hide an error in the other. Three kinds of test separate them. The first has all words at zero, which leaves only the corrections. The second has one carry word of 1, which exposes the weight. The third has mixed signed words and the full-scale extremes, where both effects and sign extension act together. Each result is compared with the arithmetic sum computed in the bench. A second overlap is a new load arriving while the previous result is still on the output. Back-to-back samples and a sample with partial done bits check that loading and holding never mix.

// File: rtl/dacomb_pkg.sv
package dacomb_pkg;

   function automatic int tree_levels(input int n);
      int lv;
      lv = 0;
      while ((1 << lv) < n) lv++;
      return lv;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/dacomb_tree.sv
module dacomb_tree #(
   parameter int  LEAVES  = 4,
   parameter int  IN_W    = 18,
   parameter bit  FIRST_CIN = 1'b0,
   localparam int LV      = dacomb_pkg::tree_levels(LEAVES),
   localparam int TW      = IN_W + LV
) (
   input  logic [LEAVES*IN_W-1:0] leaf_flat,
   output logic signed [TW-1:0]   total
);

   localparam logic signed [TW-1:0] CIN_ONE = FIRST_CIN ? TW'(1) : '0;

   if (!dacomb_pkg::is_pow2(LEAVES)) begin : g_bad_leaves
      $error("dacomb_tree: LEAVES must be a power of two, at least 2");
   end
   if (IN_W < 2) begin : g_bad_width
      $error("dacomb_tree: IN_W must be at least 2");
   end

   for (genvar l = 0; l <= LV; l++) begin : g_lvl
      localparam int CNT = LEAVES >> l;
      logic signed [TW-1:0] node [CNT];
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < CNT; i++) begin : g_ext
            assign node[i] = {{LV{leaf_flat[i*IN_W+IN_W-1]}}, leaf_flat[i*IN_W +: IN_W]};
         end
      end else begin : g_add
         for (genvar i = 0; i < CNT; i++) begin : g_pair
            if (l == 1) begin : g_first
               assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1] + CIN_ONE;
            end else begin : g_upper
               assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
            end
         end
      end
   end

   assign total = g_lvl[LV].node[0];

endmodule

// File: rtl/dacomb_merge.sv
module dacomb_merge #(
   parameter int  TW    = 20,
   localparam int RES_W = TW + 2
) (
   input  logic signed [TW-1:0]    sum_tot,
   input  logic signed [TW-1:0]    car_tot,
   output logic signed [RES_W-1:0] sum_ext,
   output logic signed [RES_W-1:0] car_dbl,
   output logic signed [RES_W-1:0] merged
);

   always_comb begin
      sum_ext = {{2{sum_tot[TW-1]}}, sum_tot};
      car_dbl = {car_tot[TW-1], car_tot, 1'b0};
      merged  = sum_ext + car_dbl;
   end

endmodule

// File: rtl/dacomb_top.sv
module dacomb_top #(
   parameter int  UNITS    = 4,
   parameter int  WORD_W   = 18,
   parameter bit  TREE_REG = 1'b0,
   localparam int LVLS     = dacomb_pkg::tree_levels(UNITS),
   localparam int OUT_W    = WORD_W + LVLS + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [UNITS*WORD_W-1:0] sum_words,
   input  logic [UNITS*WORD_W-1:0] carry_words,
   input  logic [UNITS-1:0]        unit_done,
   output logic signed [OUT_W-1:0] filt_out,
   output logic                    out_valid
);

   localparam int TW = WORD_W + LVLS;

   logic signed [TW-1:0]    s_tot, c_tot, s_use, c_use;
   logic signed [OUT_W-1:0] sum_ext, car_dbl, merged;
   logic                    all_done, ready_use;

   assign all_done = &unit_done;

   // R1 R2: two independent trees, sign-extended leaves
   dacomb_tree #(.LEAVES(UNITS), .IN_W(WORD_W), .FIRST_CIN(1'b0)) u_sum_tree (
      .leaf_flat (sum_words),
      .total     (s_tot)
   );

   // R3: UNITS/2 carry-ins at doubled weight give UNITS corrections
   dacomb_tree #(.LEAVES(UNITS), .IN_W(WORD_W), .FIRST_CIN(1'b1)) u_car_tree (
      .leaf_flat (carry_words),
      .total     (c_tot)
   );

   if (TREE_REG) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_use     <= '0;
            c_use     <= '0;
            ready_use <= 1'b0;
         end else begin
            s_use     <= s_tot;
            c_use     <= c_tot;
            ready_use <= all_done;
         end
      end
   end else begin : g_flow
      assign s_use     = s_tot;
      assign c_use     = c_tot;
      assign ready_use = all_done;
   end

   // R8: carry total at twice the weight
   dacomb_merge #(.TW(TW)) u_merge (
      .sum_tot (s_use),
      .car_tot (c_use),
      .sum_ext (sum_ext),
      .car_dbl (car_dbl),
      .merged  (merged)
   );

   // R4 R5 R6 R7
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_out  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= ready_use;
         if (ready_use) filt_out <= merged;
      end
   end

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_ext[OUT_W-1] == car_dbl[OUT_W-1]) |-> (merged[OUT_W-1] == sum_ext[OUT_W-1]))
      else $error("final add overflowed");

   if (!TREE_REG) begin : g_chk_flow
      p_valid_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (&unit_done) |=> out_valid)
         else $error("valid missing after all done");
      p_no_valid_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !(&unit_done) |=> !out_valid)
         else $error("valid without all done");
      p_hold_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !(&unit_done) |=> $stable(filt_out))
         else $error("output moved without all done");
   end else begin : g_chk_pipe
      p_valid_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ready_use |=> out_valid)
         else $error("valid missing after staged done");
      p_hold_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !ready_use |=> ($stable(filt_out) && !out_valid))
         else $error("output moved without staged done");
   end

endmodule

// File: tb/dacomb_top_tb.sv
module dacomb_top_tb_top;

   localparam int CLK_P  = 10;
   localparam int UNITS  = 4;
   localparam int WORD_W = 18;
   localparam int OUT_W  = WORD_W + 2 + 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [UNITS*WORD_W-1:0] sum_words = '0;
   logic [UNITS*WORD_W-1:0] carry_words = '0;
   logic [UNITS-1:0]        unit_done = '0;
   logic signed [OUT_W-1:0] filt_out;
   logic                    out_valid;

   int checks = 0;
   int failures = 0;

   always #(CLK_P/2) clk = ~clk;

   dacomb_top #(.UNITS(UNITS), .WORD_W(WORD_W), .TREE_REG(1'b0)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sum_words   (sum_words),
      .carry_words (carry_words),
      .unit_done   (unit_done),
      .filt_out    (filt_out),
      .out_valid   (out_valid)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint model(input longint s[4], input longint c[4]);
      longint acc = UNITS;
      for (int i = 0; i < UNITS; i++) acc += s[i] + 2 * c[i];
      return acc;
   endfunction

   task automatic drive(input longint s[4], input longint c[4], input logic [3:0] d);
      for (int i = 0; i < UNITS; i++) begin
         sum_words[i*WORD_W +: WORD_W]   = s[i][WORD_W-1:0];
         carry_words[i*WORD_W +: WORD_W] = c[i][WORD_W-1:0];
      end
      unit_done = d;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic load_and_check(input string req, input longint s[4], input longint c[4]);
      drive(s, c, 4'hF);
      step();
      chk(req, longint'(filt_out), model(s, c));
      chk(req, longint'(out_valid), 1);
   endtask

   task automatic t_reset();
      chk("R6", longint'(filt_out), 0);
      chk("R6", longint'(out_valid), 0);
   endtask

   task automatic t_zero_correction();
      load_and_check("R3", '{0, 0, 0, 0}, '{0, 0, 0, 0});
      chk("R3", longint'(filt_out), 4);
   endtask

   task automatic t_carry_weight();
      load_and_check("R8", '{0, 0, 0, 0}, '{1, 0, 0, 0});
      chk("R8", longint'(filt_out), 6);
   endtask

   task automatic t_mixed();
      load_and_check("R1", '{100, -250, 7, -1}, '{-3, 40, 0, -128});
      load_and_check("R1", '{-5000, 1234, -77, 9999}, '{0, -600, 321, 15});
   endtask

   task automatic t_extremes();
      longint mx = (longint'(1) << (WORD_W - 1)) - 1;
      longint mn = -(longint'(1) << (WORD_W - 1));
      load_and_check("R2", '{mx, mx, mx, mx}, '{mx, mx, mx, mx});
      load_and_check("R2", '{mn, mn, mn, mn}, '{mn, mn, mn, mn});
   endtask

   task automatic t_partial_done();
      longint held;
      load_and_check("R5", '{11, 22, 33, 44}, '{1, 2, 3, 4});
      held = longint'(filt_out);
      drive('{500, 600, 700, 800}, '{9, 9, 9, 9}, 4'b1011);
      step();
      chk("R5", longint'(filt_out), held);
      chk("R5", longint'(out_valid), 0);
      drive('{-1, -1, -1, -1}, '{-1, -1, -1, -1}, 4'b0000);
      step();
      chk("R5", longint'(filt_out), held);
      chk("R5", longint'(out_valid), 0);
   endtask

   task automatic t_back_to_back();
      load_and_check("R7", '{1, 2, 3, 4}, '{5, 6, 7, 8});
      load_and_check("R7", '{-10, 20, -30, 40}, '{-1, -2, 3, 4});
      load_and_check("R7", '{1000, 0, 0, -1000}, '{0, 77, -77, 0});
   endtask

   task automatic t_latency();
      drive('{3, 3, 3, 3}, '{0, 0, 0, 0}, 4'hF);
      step();
      chk("R4", longint'(out_valid), 1);
      chk("R4", longint'(filt_out), 16);
      drive('{3, 3, 3, 3}, '{0, 0, 0, 0}, 4'h7);
      step();
      chk("R4", longint'(out_valid), 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      failures++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      step();
      t_zero_correction();
      t_carry_weight();
      t_mixed();
      t_extremes();
      t_partial_done();
      t_back_to_back();
      t_latency();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule